// File: doc/BRIEF.md
# Memory-Mapped GPIO Register Controller

This block is a general-purpose pin controller that sits behind a simple register bus. Each pin has an output latch, a direction bit and a synchronized input. Software can load the whole output latch through a data register. It can also change individual bits atomically through a set register and a clear register, so no read-modify-write sequence is needed. A direction register chooses, per pin, whether the pad is driven.

The pin count equals the register width. Build-time parameters choose four things: the width (8, 16, 32 or 64), the meaning of a 1 in the direction register (output or input), whether pin numbering is reversed against register bit numbering, and whether the bus sees the register bytes in swapped order. The block exports only output-value and output-enable vectors. Pad buffers are left to the chip.

Top module: `gpio_mmio_ctrl`

## Requirements
- R1: After reset every output latch bit is 0 and every output enable is 0. The direction register reads all zeros when DIR_IS_INPUT=0 and all ones when DIR_IS_INPUT=1.
- R2: A write to word offset 0 loads the whole output latch, and pin_o shows the new value after the next rising clock edge.
- R3: A write to word offset 1 ORs the written word into the output latch. Bits written as 0 keep their value.
- R4: A write to word offset 2 clears each latch bit whose written bit is 1 and keeps the others. A read of offset 2 returns 0.
- R5: A read of offset 0 returns the pin levels after a two-flop synchronizer. A pin change applied before rising edge k is visible in read data after edge k+1, and not after edge k.
- R6: A read of offset 1 returns the current output latch.
- R7: Offset 3 is the readable and writable direction register. With DIR_IS_INPUT=0 a 1 enables the pin's output. With DIR_IS_INPUT=1 a 1 makes the pin an input, so the output enable is the inverted bit.
- R8: With BIT_REVERSE=1, pin n corresponds to register bit WIDTH-1-n for output, output enable and input. With BIT_REVERSE=0, pin n corresponds to bit n.
- R9: With BYTE_SWAP=1, bus byte lane i carries register byte NB-1-i, both on write data and on read data, where NB=WIDTH/8. Byte swapping is legal only with WIDTH 16 or 32. Any other width combined with BYTE_SWAP=1, and any width other than 8/16/32/64, stops elaboration.
- R10: Writes to offsets 4 to 7 change no state. Reads there return 0, and rdata_o is 0 whenever rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word offset |
| wdata_i | input | WIDTH | Write data, bus view |
| rdata_o | output | WIDTH | Read data, bus view, combinational |
| pin_i | input | WIDTH | Pin input levels, asynchronous |
| pin_o | output | WIDTH | Pin output values |
| pin_oe_o | output | WIDTH | Pin output enables |

## Verification
The hardest case to reach from the ports is a combined build: input polarity, reversed numbering and byte swapping all stack in one path. There, a single written bus bit lands on a pin far from its bus position, and a defect in any one stage can be masked by another. The bench runs a second instance with all three options enabled. It drives one-hot and half-populated words whose expected pin positions are worked out by hand through swap, then reversal, then polarity. The synchronizer latency is checked by sampling read data one edge early and on time.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_SET  = 2'd1,
    REG_CLR  = 2'd2,
    REG_DIR  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_lane_swap.sv
module gpio_lane_swap #(
  parameter int WIDTH = 32,
  parameter bit SWAP  = 1'b0
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int NB = WIDTH / 8;

  if (SWAP) begin : g_swap
    for (genvar b = 0; b < NB; b++) begin : g_lane
      assign q_o[8*b +: 8] = d_i[8*(NB-1-b) +: 8];
    end
  end else begin : g_pass
    assign q_o = d_i;
  end
endmodule

// File: rtl/gpio_bit_map.sv
// Pin/register permutation; reversal is its own inverse, so one module serves both directions.
module gpio_bit_map #(
  parameter int WIDTH   = 32,
  parameter bit REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar n = 0; n < WIDTH; n++) begin : g_bit
    if (REVERSE) begin : g_rev
      assign q_o[n] = d_i[WIDTH-1-n];
    end else begin : g_fwd
      assign q_o[n] = d_i[n];
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl.sv
module gpio_mmio_ctrl
  import gpio_pkg::*;
#(
  parameter int WIDTH        = 32,
  parameter int ADDR_W       = 3,
  parameter bit DIR_IS_INPUT = 1'b0,
  parameter bit BIT_REVERSE  = 1'b0,
  parameter bit BYTE_SWAP    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  localparam logic [WIDTH-1:0] DIR_RESET = DIR_IS_INPUT ? {WIDTH{1'b1}} : {WIDTH{1'b0}};

  if (!(WIDTH == 8 || WIDTH == 16 || WIDTH == 32 || WIDTH == 64)) begin : g_bad_width
    $error("gpio_mmio_ctrl: WIDTH must be 8, 16, 32 or 64");
  end
  if (BYTE_SWAP && !(WIDTH == 16 || WIDTH == 32)) begin : g_bad_swap
    $error("gpio_mmio_ctrl: BYTE_SWAP needs WIDTH 16 or 32");
  end
  if (ADDR_W < 3) begin : g_bad_addr
    $error("gpio_mmio_ctrl: ADDR_W must be at least 3");
  end

  logic [WIDTH-1:0] wr_word, rd_word, out_q, dir_q, in_sync, in_reg, oe_reg;
  logic             mapped;
  gpio_reg_e        sel;

  gpio_lane_swap #(.WIDTH(WIDTH), .SWAP(BYTE_SWAP)) u_wswap (.d_i(wdata_i), .q_o(wr_word));
  gpio_lane_swap #(.WIDTH(WIDTH), .SWAP(BYTE_SWAP)) u_rswap (.d_i(rd_word), .q_o(rdata_o));

  gpio_sync #(.WIDTH(WIDTH), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (in_sync)
  );

  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_in  (.d_i(in_sync), .q_o(in_reg));
  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_out (.d_i(out_q),   .q_o(pin_o));
  gpio_bit_map #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) u_map_oe  (.d_i(oe_reg),  .q_o(pin_oe_o));

  assign oe_reg = DIR_IS_INPUT ? ~dir_q : dir_q;
  assign mapped = (addr_i[ADDR_W-1:2] == '0);
  assign sel    = gpio_reg_e'(addr_i[1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= DIR_RESET;
    end else if (wr_en_i && mapped) begin
      unique case (sel)
        REG_DATA: out_q <= wr_word;
        REG_SET:  out_q <= out_q | wr_word;
        REG_CLR:  out_q <= out_q & ~wr_word;
        REG_DIR:  dir_q <= wr_word;
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_en_i && mapped) begin
      unique case (sel)
        REG_DATA: rd_word = in_reg;
        REG_SET:  rd_word = out_q;
        REG_CLR:  rd_word = '0;
        REG_DIR:  rd_word = dir_q;
        default:  rd_word = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_mmio_ctrl_chk.sv
module gpio_mmio_ctrl_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  wr_word,
  input logic [WIDTH-1:0]  out_q,
  input logic [WIDTH-1:0]  dir_q
);
  p_data_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(0)) |=> out_q == $past(wr_word));

  p_set_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(1)) |=> out_q == ($past(out_q) | $past(wr_word)));

  p_clr_andn_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(2)) |=> out_q == ($past(out_q) & ~$past(wr_word)));

  p_clr_read_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == ADDR_W'(2)) |-> rdata_o == '0);

  p_dir_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(3)) |=> dir_q == $past(wr_word));

  p_hold_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i[ADDR_W-1:2] == '0) |=> ($stable(out_q) && $stable(dir_q)));

  p_idle_rdata_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == '0);
endmodule

bind gpio_mmio_ctrl gpio_mmio_ctrl_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) chk_i (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .rd_en_i(rd_en_i),
  .addr_i (addr_i),
  .rdata_o(rdata_o),
  .wr_word(wr_word),
  .out_q  (out_q),
  .dir_q  (dir_q)
);

// File: tb/gpio_mmio_ctrl_tb_top.sv
module gpio_mmio_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // main instance: 32 bit, output polarity, no reversal, no swap
  logic        wr_en = 0, rd_en = 0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, pin_in = '0, pin_out, pin_oe;

  gpio_mmio_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  // combined instance: 16 bit, input polarity, reversed, byte swapped
  logic        a_wr_en = 0, a_rd_en = 0;
  logic [2:0]  a_addr = '0;
  logic [15:0] a_wdata = '0, a_rdata, a_pin_in = '0, a_pin_out, a_pin_oe;

  gpio_mmio_ctrl #(.WIDTH(16), .DIR_IS_INPUT(1'b1), .BIT_REVERSE(1'b1), .BYTE_SWAP(1'b1)) dut_alt_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(a_wr_en), .rd_en_i(a_rd_en), .addr_i(a_addr),
    .wdata_i(a_wdata), .rdata_o(a_rdata), .pin_i(a_pin_in), .pin_o(a_pin_out), .pin_oe_o(a_pin_oe)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 32'h0000_00FF, 32'h0},          // R2 load
    '{1'b0, 3'd1, 32'h0,         32'h0000_00FF},  // R6 readback
    '{1'b1, 3'd1, 32'h0000_F000, 32'h0},          // R3 set
    '{1'b0, 3'd1, 32'h0,         32'h0000_F0FF},  // R3
    '{1'b1, 3'd2, 32'h0000_000F, 32'h0},          // R4 clear
    '{1'b0, 3'd1, 32'h0,         32'h0000_F0F0},  // R4
    '{1'b0, 3'd2, 32'h0,         32'h0},          // R4 clear reads 0
    '{1'b1, 3'd4, 32'hFFFF_FFFF, 32'h0},          // R10 unmapped write
    '{1'b0, 3'd1, 32'h0,         32'h0000_F0F0},  // R10 latch kept
    '{1'b0, 3'd5, 32'h0,         32'h0},          // R10 unmapped read
    '{1'b1, 3'd3, 32'h0000_FFFF, 32'h0},          // R7 direction
    '{1'b0, 3'd3, 32'h0,         32'h0000_FFFF}   // R7 readback
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    rd_en = 1; addr = a; #1 d = rdata; rd_en = 0;
  endtask

  task automatic a_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); a_wr_en = 1; a_addr = a; a_wdata = d;
    @(negedge clk); a_wr_en = 0;
  endtask

  task automatic a_rd(logic [2:0] a, output logic [15:0] d);
    a_rd_en = 1; a_addr = a; #1 d = a_rdata; a_rd_en = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [15:0] ar;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_o", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    rd(3'd3, r); check("R1 dir out-pol", r, 32'h0);
    check("R1 alt pin_oe", {16'h0, a_pin_oe}, 32'h0);
    a_rd(3'd3, ar); check("R1 alt dir in-pol", {16'h0, ar}, 32'h0000_FFFF);
    check("R10 idle rdata", rdata, 32'h0);

    // register table: R2 R3 R4 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].wr) wr(VECS[i].a, VECS[i].d);
      else begin
        rd(VECS[i].a, r);
        check($sformatf("table vector %0d", i), r, VECS[i].e);
      end
    end

    check("R2 pin_o after table", pin_out, 32'h0000_F0F0);
    check("R7 out-pol oe", pin_oe, 32'h0000_FFFF);

    // R2 pin_o updates after exactly one edge
    @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 32'hDEAD_BEEF;
    #1 check("R2 before edge", pin_out, 32'h0000_F0F0);
    @(negedge clk); wr_en = 0;
    check("R2 after edge", pin_out, 32'hDEAD_BEEF);

    // R5 synchronizer latency
    @(negedge clk); pin_in = 32'hA5A5_0000;
    @(negedge clk); rd(3'd0, r); check("R5 one edge", r, 32'h0);
    @(negedge clk); rd(3'd0, r); check("R5 two edges", r, 32'hA5A5_0000);

    // combined instance: R8 R9 R7
    a_wr(3'd0, 16'h0001);                 // reg 0x0100 -> bit 8 -> pin 7
    check("R8 R9 alt pin_o", {16'h0, a_pin_out}, 32'h0000_0080);
    a_rd(3'd1, ar); check("R9 alt set readback", {16'h0, ar}, 32'h0000_0001);
    a_wr(3'd3, 16'h00FE);                 // reg 0xFE00: pins 0..6 inputs
    check("R7 R8 alt oe in-pol", {16'h0, a_pin_oe}, 32'h0000_FF80);
    a_rd(3'd3, ar); check("R9 alt dir readback", {16'h0, ar}, 32'h0000_00FE);
    a_wr(3'd1, 16'h8000);                 // reg 0x0080 -> bit 7 -> pin 8
    check("R3 R8 alt set", {16'h0, a_pin_out}, 32'h0000_0180);
    a_wr(3'd2, 16'h0001);                 // clear reg bit 8 -> pin 7
    check("R4 R8 alt clear", {16'h0, a_pin_out}, 32'h0000_0100);
    @(negedge clk); a_pin_in = 16'h0001;  // pin 0 -> reg bit 15 -> bus 0x0080
    repeat (2) @(negedge clk);
    a_rd(3'd0, ar); check("R5 R8 R9 alt input", {16'h0, ar}, 32'h0000_0080);
    a_wr(3'd6, 16'hFFFF);
    check("R10 alt unmapped", {16'h0, a_pin_out}, 32'h0000_0100);

    finish_run();
  end
endmodule